// File: doc/BRIEF.md
# Aligned Erase-Size Planner

This block turns a request of the form "erase N consecutive 4 KiB sectors starting at sector S" into a sequence of flash erase commands. At each step it picks the largest erase it can use at the current position. A 64 KiB erase is used when the position sits on a 16-sector boundary and at least 16 sectors remain. A 32 KiB erase is used when the position sits on an 8-sector boundary and at least 8 sectors remain. Otherwise a single 4 KiB sector erase is used.

Each command carries an opcode and a byte address, and is offered to a downstream flash command sequencer on a valid/ready handshake. The block moves its position forward by the size of every accepted command. When nothing remains, it raises a one-cycle done pulse. The serial framing of the commands belongs to the sequencer and is not part of this block.

Top module: `erase_planner`

## Requirements
- R1: After reset, `req_ready` is 1 and both `cmd_valid` and `done` are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From then until the job ends, `req_ready` is 0, and `req_valid`, `req_index` and `req_count` have no effect on the commands issued.
- R3: `cmd_addr` equals the current sector position shifted left by 12 bits. The low 12 address bits are therefore always 0.
- R4: When the position has its low 4 bits at 0 and at least 16 sectors remain, the command opcode is 0xD8 (64 KiB erase), and acceptance advances the position by 16.
- R5: When R4 does not apply, the position has its low 3 bits at 0, and at least 8 sectors remain, the opcode is 0x52 (32 KiB erase), and acceptance advances the position by 8.
- R6: In every other case the opcode is 0x20 (4 KiB erase), and acceptance advances the position by 1.
- R7: The choice is made again after every accepted command. The accepted commands cover exactly the requested sectors, in ascending order, with no gap and no overlap.
- R8: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_opcode` and `cmd_addr` hold their values into the next cycle.
- R9: A request with a count of 0 issues no command. `done` is 1 in the cycle after the request is taken.
- R10: `done` is a one-cycle pulse in the cycle after the final command is accepted. In that same cycle `cmd_valid` is 0 and `req_ready` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Erase job request |
| req_ready | output | 1 | Planner idle, can take a job |
| req_index | input | IDX_W (12) | First 4 KiB sector of the job |
| req_count | input | CNT_W (13) | Number of 4 KiB sectors to erase |
| cmd_valid | output | 1 | Erase command offered |
| cmd_ready | input | 1 | Sequencer accepts the command |
| cmd_opcode | output | 8 | Erase opcode (0x20, 0x52 or 0xD8) |
| cmd_addr | output | IDX_W+12 (24) | Byte address of the erase |
| done | output | 1 | One-cycle pulse at job completion |

## Verification
The first command is visible in the cycle right after the request edge, because the command outputs are decoded from registered position and remaining count. Each acceptance edge moves the next command into the following cycle. `done` appears one cycle after the final acceptance edge, or one cycle after the request edge when the count is 0.

The bench drives inputs and samples outputs at the falling edge. It keeps its own position and remaining count, updated only on cycles where it offered `cmd_ready` while `cmd_valid` was high, and compares every offered command against that model. During random stalls it also pokes new requests at the planner, to show that they change nothing.

// File: rtl/erase_plan_pkg.sv
package erase_plan_pkg;

  // Base erase unit is one 4 KiB sector
  localparam int unsigned SECTOR_SHIFT = 12;

  // Opcodes understood by the downstream sequencer
  localparam logic [7:0] OPC_ERASE_4K  = 8'h20;
  localparam logic [7:0] OPC_ERASE_32K = 8'h52;
  localparam logic [7:0] OPC_ERASE_64K = 8'hD8;

  // Granule sizes in sectors (powers of two)
  localparam int unsigned SPAN_SMALL = 1;
  localparam int unsigned SPAN_MID   = 8;
  localparam int unsigned SPAN_LARGE = 16;

  typedef enum logic {
    PL_IDLE  = 1'b0,
    PL_ISSUE = 1'b1
  } pl_state_e;

endpackage

// File: rtl/erase_granule_sel.sv
module erase_granule_sel
  import erase_plan_pkg::*;
#(
  parameter int unsigned IDX_W = 12,
  parameter int unsigned CNT_W = 13
) (
  input  logic [IDX_W-1:0] pos,
  input  logic [CNT_W-1:0] rem,
  output logic [7:0]       opcode,
  output logic [CNT_W-1:0] step
);

  localparam int unsigned LG_LARGE = $clog2(SPAN_LARGE);
  localparam int unsigned LG_MID   = $clog2(SPAN_MID);
  localparam logic [CNT_W-1:0] LARGE_C = CNT_W'(SPAN_LARGE);
  localparam logic [CNT_W-1:0] MID_C   = CNT_W'(SPAN_MID);
  localparam logic [CNT_W-1:0] SMALL_C = CNT_W'(SPAN_SMALL);

  logic fits_large;
  logic fits_mid;

  // Alignment by low-bit masks; coverage by remaining count
  assign fits_large = (pos[LG_LARGE-1:0] == '0) && (rem >= LARGE_C);
  assign fits_mid   = (pos[LG_MID-1:0]   == '0) && (rem >= MID_C);

  always_comb begin
    if (fits_large) begin
      opcode = OPC_ERASE_64K;
      step   = LARGE_C;
    end else if (fits_mid) begin
      opcode = OPC_ERASE_32K;
      step   = MID_C;
    end else begin
      opcode = OPC_ERASE_4K;
      step   = SMALL_C;
    end
  end

endmodule

// File: rtl/erase_cursor.sv
module erase_cursor #(
  parameter int unsigned IDX_W = 12,
  parameter int unsigned CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             adv,
  input  logic [CNT_W-1:0] step,
  output logic [IDX_W-1:0] pos,
  output logic [CNT_W-1:0] rem,
  output logic             last
);

  logic [IDX_W-1:0] pos_d;
  logic [CNT_W-1:0] rem_d;
  logic             upd;

  assign upd  = load | adv;
  assign last = (rem == step);

  always_comb begin
    pos_d = pos;
    rem_d = rem;
    if (load) begin
      pos_d = load_idx;
      rem_d = load_cnt;
    end else if (adv) begin
      pos_d = pos + IDX_W'(step);
      rem_d = rem - step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      rem <= '0;
    end else if (upd) begin
      pos <= pos_d;
      rem <= rem_d;
    end
  end

  // R7: an accepted command never covers more sectors than remain
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (rem >= step));

  // R7: remaining count shrinks by exactly the accepted step
  assert_rem_shrink_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (rem == $past(rem) - $past(step)));

endmodule

// File: rtl/erase_planner.sv
module erase_planner
  import erase_plan_pkg::*;
#(
  parameter int unsigned IDX_W = 12,
  parameter int unsigned CNT_W = 13
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [IDX_W-1:0]              req_index,
  input  logic [CNT_W-1:0]              req_count,
  output logic                          cmd_valid,
  input  logic                          cmd_ready,
  output logic [7:0]                    cmd_opcode,
  output logic [IDX_W+SECTOR_SHIFT-1:0] cmd_addr,
  output logic                          done
);

  localparam int unsigned ADDR_W = IDX_W + SECTOR_SHIFT;
  localparam int unsigned LG_LARGE = $clog2(SPAN_LARGE);
  localparam int unsigned LG_MID   = $clog2(SPAN_MID);

  pl_state_e        state_q, state_d;
  logic             done_q, done_d;
  logic             accept;
  logic             handshake;
  logic [IDX_W-1:0] pos;
  logic [CNT_W-1:0] rem;
  logic [CNT_W-1:0] step;
  logic             last;

  assign req_ready = (state_q == PL_IDLE);
  assign cmd_valid = (state_q == PL_ISSUE);
  assign accept    = req_valid & req_ready;
  assign handshake = cmd_valid & cmd_ready;
  assign done      = done_q;
  assign cmd_addr  = {pos, {SECTOR_SHIFT{1'b0}}};

  erase_granule_sel #(
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
  ) u_sel (
    .pos    (pos),
    .rem    (rem),
    .opcode (cmd_opcode),
    .step   (step)
  );

  erase_cursor #(
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
  ) u_cursor (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_idx (req_index),
    .load_cnt (req_count),
    .adv      (handshake),
    .step     (step),
    .pos      (pos),
    .rem      (rem),
    .last     (last)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    unique case (state_q)
      PL_IDLE: begin
        if (accept) begin
          if (req_count == '0) begin
            done_d = 1'b1;
          end else begin
            state_d = PL_ISSUE;
          end
        end
      end
      PL_ISSUE: begin
        if (handshake && last) begin
          state_d = PL_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = PL_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PL_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  // R2: never accepting a job and offering a command at once
  assert_busy_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid);

  // R3: byte address always sector aligned
  assert_addr_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_addr[SECTOR_SHIFT-1:0] == '0));

  // R4: large erase only at a 16-sector boundary
  assert_large_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_opcode == OPC_ERASE_64K) |->
      (cmd_addr[SECTOR_SHIFT+LG_LARGE-1:SECTOR_SHIFT] == '0));

  // R5: mid erase only at an 8-sector boundary
  assert_mid_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_opcode == OPC_ERASE_32K) |->
      (cmd_addr[SECTOR_SHIFT+LG_MID-1:SECTOR_SHIFT] == '0));

  // R8: a stalled command holds steady
  assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_opcode) && $stable(cmd_addr)));

  // R10: done only while idle
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !cmd_valid));

  // R10: done lasts one cycle unless a new empty job follows at once
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req_valid) |=> !done);

endmodule

// File: tb/erase_planner_bench.sv
module erase_planner_bench;

  localparam int unsigned IDX_W  = 12;
  localparam int unsigned CNT_W  = 13;
  localparam int unsigned ADDR_W = IDX_W + 12;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [IDX_W-1:0]  req_index;
  logic [CNT_W-1:0]  req_count;
  logic              cmd_valid;
  logic              cmd_ready;
  logic [7:0]        cmd_opcode;
  logic [ADDR_W-1:0] cmd_addr;
  logic              done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  erase_planner #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_erase_planner (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_index  (req_index),
    .req_count  (req_count),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_opcode (cmd_opcode),
    .cmd_addr   (cmd_addr),
    .done       (done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_step(input int pos, input int rem);
    if ((pos % 16) == 0 && rem >= 16) return 16;
    if ((pos % 8) == 0 && rem >= 8) return 8;
    return 1;
  endfunction

  function automatic int exp_op(input int pos, input int rem);
    int s;
    s = exp_step(pos, rem);
    if (s == 16) return 'hD8;
    if (s == 8) return 'h52;
    return 'h20;
  endfunction

  // Runs one job; ready_pct sets sequencer acceptance odds, poke sends junk requests
  task automatic run_job(input int idx, input int cnt, input int ready_pct, input bit poke);
    int pos;
    int rem;
    int guard;
    bit rdy;
    pos = idx;
    rem = cnt;
    check(req_ready == 1'b1, "R2 idle ready", req_ready, 1);
    req_valid = 1'b1;
    req_index = IDX_W'(idx);
    req_count = CNT_W'(cnt);
    @(negedge clk);
    req_valid = 1'b0;
    if (cnt == 0) begin
      check(done == 1'b1, "R9 done on empty job", done, 1);
      check(cmd_valid == 1'b0, "R9 no command on empty job", cmd_valid, 0);
      @(negedge clk);
      check(done == 1'b0, "R10 done single pulse", done, 0);
      return;
    end
    guard = 0;
    while (rem > 0 && guard < 20000) begin
      guard++;
      check(cmd_valid == 1'b1, "R7 command offered", cmd_valid, 1);
      check(req_ready == 1'b0, "R2 busy not ready", req_ready, 0);
      check(done == 1'b0, "R10 no early done", done, 0);
      check(cmd_opcode == 8'(exp_op(pos, rem)), "R4/R5/R6 opcode", cmd_opcode, exp_op(pos, rem));
      check(cmd_addr == ADDR_W'(pos) << 12, "R3 address", cmd_addr, longint'(pos) << 12);
      rdy = ($urandom_range(99) < ready_pct);
      cmd_ready = rdy;
      if (poke) begin
        req_valid = 1'b1;
        req_index = IDX_W'($urandom);
        req_count = CNT_W'($urandom_range(40));
      end
      @(negedge clk);
      cmd_ready = 1'b0;
      req_valid = 1'b0;
      if (rdy) begin
        int s;
        s = exp_step(pos, rem);
        pos += s;
        rem -= s;
      end
    end
    check(done == 1'b1, "R10 done after last accept", done, 1);
    check(cmd_valid == 1'b0, "R10 command dropped", cmd_valid, 0);
    check(req_ready == 1'b1, "R10 ready again", req_ready, 1);
    @(negedge clk);
    check(done == 1'b0, "R10 done single pulse", done, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_index = '0;
    req_count = '0;
    cmd_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1 && cmd_valid == 1'b0 && done == 1'b0, "R1 reset state",
          {req_ready, cmd_valid, done}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after release", req_ready, 1);

    // Directed corner cases
    run_job(0, 0, 100, 0);        // R9
    run_job(0, 16, 100, 0);       // R4 exact large
    run_job(8, 24, 100, 0);       // R5 then R4
    run_job(15, 1, 100, 0);       // R6 single
    run_job(4095, 1, 100, 0);     // R3 top sector
    run_job(7, 40, 50, 1);        // R7 mixed, R8 stalls, R2 pokes
    run_job(16, 15, 30, 1);       // R5 mid then small, no large
    run_job(0, 4096, 100, 0);     // whole range
    run_job(33, 0, 100, 0);       // R9 again

    // Random jobs
    for (int j = 0; j < 60; j++) begin
      int idx;
      int cnt;
      idx = $urandom_range(4095);
      cnt = $urandom_range(80);
      if (idx + cnt > 4096) cnt = 4096 - idx;
      run_job(idx, cnt, $urandom_range(20, 100), j[0]);
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule